// File: doc/BRIEF.md
# I2C Target Register-Bank Interface

This block lets an I2C bus master reach a bank of 8-bit registers that sit outside it. It watches the open-drain clock and data lines and recognises START, repeated START and STOP. It answers one 7-bit device address. After the address it takes a register pointer byte and then moves data bytes in either direction. The pointer steps forward after every data byte, so a single transfer can cover a run of consecutive registers.

A pointer set in a write phase is kept through a repeated START. A following read therefore continues from where the write left off. The register storage is not part of the block. Each byte is exchanged with it over one valid/ready request channel: a write carries the byte, and a read returns it in the handshake cycle. While a request waits for `req_ready_i`, the block pulls SCL low, which holds the master in a wait state.

Both bus lines pass through two-flop synchronizers. Every bus event is then detected in the system clock domain.

Top module: `i2c_regbank_target`

## Requirements
- R1: While reset is asserted and directly after it, neither bus line is pulled low and `req_valid_o` is 0.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged (SDA pulled low in the ninth clock); bit 0 of that byte selects the direction, 0 meaning write. Any other address gets no acknowledge, and the block ignores every following byte until the next START, so no register changes.
- R3: In a write, the byte after the address is the register pointer. Each following data byte is acknowledged and is issued as a request with `req_we_o`=1, `req_addr_o` equal to the pointer and `req_wdata_o` equal to the byte.
- R4: The pointer advances by one after every data byte in both directions. Its value survives a repeated START, so a read that follows without a new pointer byte starts at the register after the last one written.
- R5: A register pointer byte with bit 7 set is not acknowledged, causes no request, and the block ignores the bus until the next START.
- R6: After a repeated START with address+R, the block requests the register at the pointer and shifts the returned byte onto SDA most significant bit first. Further bytes come from consecutive registers.
- R7: When the master answers a read byte with NACK, the block releases SDA within the following low phase of SCL and does not drive it again before a new START.
- R8: While a request is outstanding and `req_ready_i` is low, SCL is pulled low. SCL is released on the clock after the handshake.
- R9: Once `req_valid_o` is raised, it stays high with stable `req_we_o`, `req_addr_o` and `req_wdata_o` until the cycle `req_ready_i` is high. For a read request, `req_rdata_i` is taken in that handshake cycle.
- R10: The block changes its SDA output only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 pulls SDA low |
| req_valid_o | output | 1 | Register request pending |
| req_ready_i | input | 1 | Register side accepts the request |
| req_we_o | output | 1 | 1 = write request, 0 = read request |
| req_addr_o | output | 7 | Register index (the pointer) |
| req_wdata_o | output | 8 | Byte to be written |
| req_rdata_i | input | 8 | Byte read, valid in the handshake cycle |

## Verification
The completion of a register handshake and the move of the SDA output fall in the same clock cycle. At that point the block drives its acknowledge or the first bit of a read byte. SCL is still being held low, and it is released one cycle later. The bench provokes this by sweeping the register side's acceptance delay from zero up to well past the master's low phase. Each sweep point is judged three ways: the SCL stretch length the master observes, the data returned, and a monitor that counts SDA changes made while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = BYTE_W - 1;
  localparam int DADDR_W = 7;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tgt_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output i2c_tgt_pkg::bus_ev_t ev_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, syn;
  logic scl_s, sda_s, scl_p, sda_p;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[g]),
      .q    (syn[g])
    );
  end

  assign scl_s = syn[1];
  assign sda_s = syn[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign ev_o.scl_rise = scl_s & ~scl_p;
  assign ev_o.scl_fall = ~scl_s & scl_p;
  assign ev_o.start    = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_o.stop     = scl_s & scl_p & ~sda_p & sda_s;
  assign ev_o.sda      = sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [DADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [PTR_W-1:0]  req_addr,
  output logic [BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0] req_rdata,
  output logic              sda_low,
  output logic              scl_low
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh;
  logic [PTR_W-1:0]   ptr;
  logic               rw, mack, pend, sda_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      pend   <= 1'b0;
      sda_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= pend;
      if (ev.stop) begin
        state <= ST_IDLE;
        sda_q <= 1'b0;
        pend  <= 1'b0;
      end else if (ev.start) begin
        state <= ST_ADDR;
        cnt   <= '0;
        sda_q <= 1'b0;
        pend  <= 1'b0;
      end else if (pend) begin
        if (req_ready) begin
          pend <= 1'b0;
          ptr  <= ptr + 1'b1;
          if (state == ST_WDATA_ACK) begin
            sda_q <= 1'b1;
          end else begin
            sh    <= req_rdata;
            sda_q <= ~req_rdata[BYTE_W-1];
            cnt   <= '0;
          end
        end
      end else begin
        case (state)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (ev.scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], ev.sda};
              cnt <= cnt + 1'b1;
            end else if (ev.scl_fall && cnt == FULL) begin
              if (state == ST_ADDR) begin
                if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_q <= 1'b1;
                  rw    <= sh[0];
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_REG) begin
                if (!sh[BYTE_W-1]) begin
                  sda_q <= 1'b1;
                  ptr   <= sh[PTR_W-1:0];
                  state <= ST_REG_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_WDATA_ACK;
                pend  <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev.scl_fall) begin
              sda_q <= 1'b0;
              cnt   <= '0;
              if (rw) begin
                state <= ST_RDATA;
                pend  <= 1'b1;
              end else begin
                state <= ST_REG;
              end
            end
          end
          ST_REG_ACK, ST_WDATA_ACK: begin
            if (ev.scl_fall) begin
              sda_q <= 1'b0;
              cnt   <= '0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (ev.scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (ev.scl_fall) begin
              if (cnt == FULL) begin
                sda_q <= 1'b0;
                state <= ST_RDATA_ACK;
              end else begin
                sh    <= {sh[BYTE_W-2:0], 1'b0};
                sda_q <= ~sh[BYTE_W-2];
              end
            end
          end
          ST_RDATA_ACK: begin
            if (ev.scl_rise) begin
              mack <= ~ev.sda;
            end else if (ev.scl_fall) begin
              if (mack) begin
                state <= ST_RDATA;
                pend  <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign req_valid = pend;
  assign req_we    = (state == ST_WDATA_ACK);
  assign req_addr  = ptr;
  assign req_wdata = sh;
  assign sda_low   = sda_q;
  assign scl_low   = hold_q;
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [DADDR_W-1:0] DEV_ADDR    = 7'h2A,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [PTR_W-1:0]  req_addr_o,
  output logic [BYTE_W-1:0] req_wdata_o,
  input  logic [BYTE_W-1:0] req_rdata_i
);
  bus_ev_t ev;

  i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_i(scl_i),
    .sda_i(sda_i),
    .ev_o (ev)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .req_valid(req_valid_o),
    .req_ready(req_ready_i),
    .req_we   (req_we_o),
    .req_addr (req_addr_o),
    .req_wdata(req_wdata_o),
    .req_rdata(req_rdata_i),
    .sda_low  (sda_low_o),
    .scl_low  (scl_low_o)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              scl_low_o,
  input logic              sda_low_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_we_o,
  input logic [PTR_W-1:0]  req_addr_o,
  input logic [BYTE_W-1:0] req_wdata_o
);
  // R10: own SDA output moves only while the clock line is low
  assert_sda_moves_in_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> !scl_i);

  // R9: a stalled request keeps its fields
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_we_o) && $stable(req_addr_o) && $stable(req_wdata_o)));

  // R8: a stalled request stretches the clock
  assert_stall_holds_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> scl_low_o);

  // R8: stretching only follows a pending request
  assert_stretch_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low_o |-> $past(req_valid_o));

  // R8: requests are raised during a low clock phase
  assert_req_rises_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> !scl_i);
endmodule

bind i2c_regbank_target i2c_tgt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .scl_low_o  (scl_low_o),
  .sda_low_o  (sda_low_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_we_o   (req_we_o),
  .req_addr_o (req_addr_o),
  .req_wdata_o(req_wdata_o)
);

// File: tb/sim_i2c_regbank_target.sv
module sim_i2c_regbank_target;
  localparam logic [6:0] DEV = 7'h3C;
  localparam int H = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       scl_line, sda_line;
  logic       scl_low_o, sda_low_o, req_valid_o, req_ready_i, req_we_o;
  logic [6:0] req_addr_o;
  logic [7:0] req_wdata_o, req_rdata_i;

  assign scl_line = ~(m_scl_low | scl_low_o);
  assign sda_line = ~(m_sda_low | sda_low_o);

  i2c_regbank_target #(.DEV_ADDR(DEV)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o),
    .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i),
    .req_we_o   (req_we_o),
    .req_addr_o (req_addr_o),
    .req_wdata_o(req_wdata_o),
    .req_rdata_i(req_rdata_i)
  );

  // register-side harness: 16 bytes, acceptance delay of lat cycles
  logic [7:0] mem [16];
  logic [7:0] expm [16];
  int lat = 0;
  int wcnt;

  assign req_ready_i = req_valid_o && (wcnt >= lat);
  assign req_rdata_i = mem[req_addr_o[3:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= 0;
      for (int k = 0; k < 16; k++) mem[k] <= 8'h00;
    end else begin
      if (!req_valid_o || req_ready_i) wcnt <= 0;
      else                             wcnt <= wcnt + 1;
      if (req_valid_o && req_ready_i && req_we_o) mem[req_addr_o[3:0]] <= req_wdata_o;
    end
  end

  int checks = 0, fails = 0, st_max = 0, viol = 0;
  logic sda_prev = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (sda_low_o !== sda_prev && scl_line) viol++;
      sda_prev = sda_low_o;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rel_wait();
    int s;
    m_scl_low = 1'b0;
    s = 0;
    wt(1);
    while (!scl_line) begin
      s++;
      wt(1);
    end
    if (s > st_max) st_max = s;
  endtask

  task automatic write_bit(input logic b);
    wt(5); m_sda_low = ~b; wt(5);
    rel_wait(); wt(H); m_scl_low = 1'b1;
  endtask

  task automatic read_bit(output logic v);
    m_sda_low = 1'b0; wt(10);
    rel_wait(); wt(5); v = sda_line; wt(5); m_scl_low = 1'b1;
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) write_bit(d[i]);
    read_bit(v);
    ack = ~v;
  endtask

  task automatic rbyte(input bit last, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      read_bit(v);
      d[i] = v;
    end
    write_bit(last);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; wt(H); m_scl_low = 1'b1;
  endtask

  task automatic bus_rstart();
    wt(5); m_sda_low = 1'b0; wt(5);
    rel_wait(); wt(H); m_sda_low = 1'b1; wt(H); m_scl_low = 1'b1;
  endtask

  task automatic bus_stop();
    wt(5); m_sda_low = 1'b1; wt(5);
    rel_wait(); wt(H); m_sda_low = 1'b0; wt(H);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int k = 0; k < 16; k++) expm[k] = 8'h00;
    rst_n = 1'b0;
    wt(5);
    // R1: reset state
    chk(scl_low_o == 1'b0, "R1 scl released in reset", int'(scl_low_o), 0);
    chk(sda_low_o == 1'b0, "R1 sda released in reset", int'(sda_low_o), 0);
    chk(req_valid_o == 1'b0, "R1 no request in reset", int'(req_valid_o), 0);
    rst_n = 1'b1;
    wt(5);
    chk(!scl_low_o && !sda_low_o && !req_valid_o, "R1 idle after reset",
        int'({scl_low_o, sda_low_o, req_valid_o}), 0);

    // sweep of start register, burst length and acceptance delay
    for (int s = 0; s < 16; s++) begin
      int n;
      case (s % 4)
        0: lat = 0;
        1: lat = 1;
        2: lat = 5;
        default: lat = 20;
      endcase
      n = 1 + (s % 3);
      st_max = 0;
      bus_start();
      wbyte({DEV, 1'b0}, ack);
      chk(ack, "R2 address+W acknowledged", int'(ack), 1);
      wbyte(8'(s), ack);
      chk(ack, "R3 pointer byte acknowledged", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
        d = 8'((s * 37 + i * 11) ^ 8'h5A);
        expm[(s + i) % 16] = d;
        wbyte(d, ack);
        chk(ack, "R3 data byte acknowledged", int'(ack), 1);
      end
      bus_stop();
      if (lat == 0)  chk(st_max == 0, "R8 no stretch when ready at once", st_max, 0);
      if (lat == 20) chk(st_max >= 10, "R8 stretch while not ready", st_max, 10);
      for (int i = 0; i < n; i++)
        chk(mem[(s + i) % 16] == expm[(s + i) % 16], "R4 burst write to consecutive registers",
            int'(mem[(s + i) % 16]), int'(expm[(s + i) % 16]));
      wt(20);
      bus_start();
      wbyte({DEV, 1'b0}, ack);
      wbyte(8'(s), ack);
      bus_rstart();
      wbyte({DEV, 1'b1}, ack);
      chk(ack, "R2 address+R acknowledged", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
        rbyte(i == n - 1, d);
        chk(d == expm[(s + i) % 16], "R6 read byte MSB first from pointer",
            int'(d), int'(expm[(s + i) % 16]));
      end
      wt(5);
      chk(sda_low_o == 1'b0, "R7 SDA released after NACK", int'(sda_low_o), 0);
      bus_stop();
      wt(20);
    end

    // R4: pointer survives repeated START into a read
    lat = 1;
    bus_start();
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'd3, ack);
    wbyte(8'hC3, ack);
    expm[3] = 8'hC3;
    bus_rstart();
    wbyte({DEV, 1'b1}, ack);
    rbyte(1'b1, d);
    chk(d == expm[4], "R4 pointer persists into read", int'(d), int'(expm[4]));
    bus_stop();
    wt(20);

    // R2: foreign address ignored
    bus_start();
    wbyte({DEV ^ 7'h11, 1'b0}, ack);
    chk(!ack, "R2 foreign address not acknowledged", int'(ack), 0);
    wbyte(8'd2, ack);
    chk(!ack, "R2 bus ignored after foreign address", int'(ack), 0);
    wbyte(8'hEE, ack);
    bus_stop();
    chk(mem[2] == expm[2], "R2 no write after foreign address", int'(mem[2]), int'(expm[2]));
    wt(20);

    // R5: pointer byte with bit 7 set
    bus_start();
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'h82, ack);
    chk(!ack, "R5 pointer with bit7 set not acknowledged", int'(ack), 0);
    wbyte(8'h77, ack);
    chk(!ack, "R5 data after bad pointer not acknowledged", int'(ack), 0);
    bus_stop();
    chk(mem[2] == expm[2], "R5 no write after bad pointer", int'(mem[2]), int'(expm[2]));

    chk(viol == 0, "R10 SDA changed while SCL high", viol, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule